// File: doc/BRIEF.md
# Register-Selected Pad Signal Multiplexer

This block connects a bank of multiplexed chip pads to the ports of on-chip peripherals. Each routing choice is held in a small select register.

- **Peripheral inputs.** Each peripheral input has an input-select register. It feeds that input from a constant 0, a constant 1, or any one pad input.
- **Pad outputs.** Each pad has an output-select register. It drives the pad with one of the following:
  - a constant 0 or constant 1, both with the output enable asserted;
  - high impedance;
  - the output of one peripheral together with that peripheral's matching output enable.

Software, or a nearby configuration block, loads the select registers through a single-cycle write port. Only the select registers are clocked. Every route from a pad or peripheral signal to an output is combinational, so a routed signal passes through with no added latency. Any select code beyond the last real source is treated as invalid. An invalid code makes the output read 0, and on a pad also drops the enable.

Top module: `pad_route_mux`

## Requirements
- R1: A peripheral input whose select code is 0 reads 0.
- R2: A peripheral input whose select code is 1 reads 1.
- R3: A peripheral input whose select code is k, with 2 <= k < 2+NUM_PADS, reads pad input k-2.
- R4: A peripheral input whose select code is NUM_PADS+2 or greater reads 0.
- R5: A pad with output-select code 0 drives output 0 with enable 1; with code 1 it drives output 1 with enable 1.
- R6: A pad with output-select code 2 is high impedance: output 0, enable 0.
- R7: A pad with output-select code k, with 3 <= k < 3+NUM_PERIPH_OUT, drives peripheral output bit k-3 and peripheral enable bit k-3.
- R8: A pad with output-select code NUM_PERIPH_OUT+3 or greater drives output 0 with enable 0.
- R9: While reset is asserted and after it is released, every select register holds 0. As a result, every peripheral input reads 0 and every pad drives 0 with enable 1.
- R10: A write takes effect at the clock edge on which `wr_en_i` is sampled high. `wr_bank_i`=0 selects the input-select array and `wr_bank_i`=1 selects the output-select array. `wr_idx_i` selects the entry, and the low field-width bits of `wr_data_i` give the new code.
- R11: A write whose index is not below the entry count of its bank changes no register. An entry that is not addressed by a write keeps its code.
- R12: Pad and peripheral values reach the routed outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the select registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for a select register |
| wr_bank_i | input | 1 | 0: input-select array, 1: output-select array |
| wr_idx_i | input | WR_IDX_W | Entry index within the chosen array |
| wr_data_i | input | WR_DATA_W | New select code |
| pad_in_i | input | NUM_PADS | Values received from the pads |
| periph_out_i | input | NUM_PERIPH_OUT | Peripheral output data |
| periph_oe_i | input | NUM_PERIPH_OUT | Peripheral output enables |
| periph_in_o | output | NUM_PERIPH_IN | Routed peripheral inputs |
| pad_out_o | output | NUM_PADS | Data driven to the pads |
| pad_oe_o | output | NUM_PADS | Output enables driven to the pads |

## Verification
The assertions check every routing rule for every entry on every cycle:
- the constant codes, the pass-through codes and the out-of-range codes, on both the input side and the pad side;
- that an addressed write lands in the next cycle;
- that unaddressed entries stay unchanged.

The bench's scenarios are needed for the behaviours a sampled property cannot show:
- the reset state reaching the ports;
- writes to invalid indices leaving every port unchanged;
- a pad or peripheral toggle reaching an output mid-cycle without any clock edge.

The bench also sweeps every code of every entry against its own model.

// File: rtl/pad_route_pkg.sv
package pad_route_pkg;
  // reserved low codes ahead of the real sources
  localparam int unsigned SEL_CONST0   = 0;
  localparam int unsigned SEL_CONST1   = 1;
  localparam int unsigned SEL_HIZ      = 2;
  localparam int unsigned IN_SRC_BASE  = 2;
  localparam int unsigned OUT_SRC_BASE = 3;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pad_sel_regs.sv
module pad_sel_regs #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned DATA_W  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output logic [ENTRIES-1:0][WIDTH-1:0]   sel_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  sel_o[e] <= '0;
      else if (hit) sel_o[e] <= wr_data_i[WIDTH-1:0];
    end
  end
endmodule

// File: rtl/pad_in_route.sv
module pad_in_route
  import pad_route_pkg::*;
#(
  parameter int unsigned NUM_PADS = 8,
  parameter int unsigned NUM_IN   = 6,
  parameter int unsigned SEL_W    = 4
) (
  input  logic [NUM_PADS-1:0]           pad_in_i,
  input  logic [NUM_IN-1:0][SEL_W-1:0]  sel_i,
  output logic [NUM_IN-1:0]             periph_in_o
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    always_comb begin
      periph_in_o[i] = 1'b0;  // const-0 and out-of-range codes
      if (sel_i[i] == SEL_W'(SEL_CONST1)) periph_in_o[i] = 1'b1;
      for (int p = 0; p < int'(NUM_PADS); p++) begin
        if (sel_i[i] == SEL_W'(int'(IN_SRC_BASE) + p)) periph_in_o[i] = pad_in_i[p];
      end
    end
  end
endmodule

// File: rtl/pad_out_route.sv
module pad_out_route
  import pad_route_pkg::*;
#(
  parameter int unsigned NUM_PADS = 8,
  parameter int unsigned NUM_OUT  = 6,
  parameter int unsigned SEL_W    = 4
) (
  input  logic [NUM_OUT-1:0]              periph_out_i,
  input  logic [NUM_OUT-1:0]              periph_oe_i,
  input  logic [NUM_PADS-1:0][SEL_W-1:0]  sel_i,
  output logic [NUM_PADS-1:0]             pad_out_o,
  output logic [NUM_PADS-1:0]             pad_oe_o
);
  for (genvar n = 0; n < NUM_PADS; n++) begin : g_pad
    always_comb begin
      pad_out_o[n] = 1'b0;  // hi-z and out-of-range codes
      pad_oe_o[n]  = 1'b0;
      if (sel_i[n] == SEL_W'(SEL_CONST0)) begin
        pad_oe_o[n] = 1'b1;
      end
      if (sel_i[n] == SEL_W'(SEL_CONST1)) begin
        pad_out_o[n] = 1'b1;
        pad_oe_o[n]  = 1'b1;
      end
      for (int s = 0; s < int'(NUM_OUT); s++) begin
        if (sel_i[n] == SEL_W'(int'(OUT_SRC_BASE) + s)) begin
          pad_out_o[n] = periph_out_i[s];
          pad_oe_o[n]  = periph_oe_i[s];
        end
      end
    end
  end
endmodule

// File: rtl/pad_route_mux.sv
module pad_route_mux
  import pad_route_pkg::*;
#(
  parameter int unsigned NUM_PADS       = 8,
  parameter int unsigned NUM_PERIPH_IN  = 6,
  parameter int unsigned NUM_PERIPH_OUT = 6,
  localparam int unsigned IN_SEL_W  = $clog2(IN_SRC_BASE + NUM_PADS),
  localparam int unsigned OUT_SEL_W = $clog2(OUT_SRC_BASE + NUM_PERIPH_OUT),
  localparam int unsigned WR_DATA_W = max_u(IN_SEL_W, OUT_SEL_W),
  localparam int unsigned WR_IDX_W  = max_u(1, $clog2(max_u(NUM_PADS, NUM_PERIPH_IN)))
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      wr_bank_i,
  input  logic [WR_IDX_W-1:0]       wr_idx_i,
  input  logic [WR_DATA_W-1:0]      wr_data_i,
  input  logic [NUM_PADS-1:0]       pad_in_i,
  input  logic [NUM_PERIPH_OUT-1:0] periph_out_i,
  input  logic [NUM_PERIPH_OUT-1:0] periph_oe_i,
  output logic [NUM_PERIPH_IN-1:0]  periph_in_o,
  output logic [NUM_PADS-1:0]       pad_out_o,
  output logic [NUM_PADS-1:0]       pad_oe_o
);
  logic [NUM_PERIPH_IN-1:0][IN_SEL_W-1:0] in_sel;
  logic [NUM_PADS-1:0][OUT_SEL_W-1:0]     out_sel;
  logic wr_in, wr_out;

  assign wr_in  = wr_en_i && !wr_bank_i;
  assign wr_out = wr_en_i &&  wr_bank_i;

  pad_sel_regs #(
    .ENTRIES(NUM_PERIPH_IN), .WIDTH(IN_SEL_W), .IDX_W(WR_IDX_W), .DATA_W(WR_DATA_W)
  ) u_in_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_in), .wr_idx_i, .wr_data_i, .sel_o(in_sel)
  );

  pad_sel_regs #(
    .ENTRIES(NUM_PADS), .WIDTH(OUT_SEL_W), .IDX_W(WR_IDX_W), .DATA_W(WR_DATA_W)
  ) u_out_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_out), .wr_idx_i, .wr_data_i, .sel_o(out_sel)
  );

  pad_in_route #(
    .NUM_PADS(NUM_PADS), .NUM_IN(NUM_PERIPH_IN), .SEL_W(IN_SEL_W)
  ) u_in_route (
    .pad_in_i, .sel_i(in_sel), .periph_in_o
  );

  pad_out_route #(
    .NUM_PADS(NUM_PADS), .NUM_OUT(NUM_PERIPH_OUT), .SEL_W(OUT_SEL_W)
  ) u_out_route (
    .periph_out_i, .periph_oe_i, .sel_i(out_sel), .pad_out_o, .pad_oe_o
  );

  // ---------------- assertions ----------------
  for (genvar i = 0; i < NUM_PERIPH_IN; i++) begin : g_ast_in
    AST_IN_CONST0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_sel[i] == '0 |-> periph_in_o[i] == 1'b0);  // R1
    AST_IN_CONST1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_sel[i] == IN_SEL_W'(1) |-> periph_in_o[i] == 1'b1);  // R2
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_p
      AST_IN_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(in_sel[i]) == 2 + p |-> periph_in_o[i] == pad_in_i[p]);  // R3
    end
    AST_IN_OOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(in_sel[i]) >= 2 + int'(NUM_PADS) |-> periph_in_o[i] == 1'b0);  // R4
    AST_IN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && !wr_bank_i && int'(wr_idx_i) == i
      |=> in_sel[i] == $past(wr_data_i[IN_SEL_W-1:0]));  // R10
    AST_IN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && !wr_bank_i && int'(wr_idx_i) == i) |=> $stable(in_sel[i]));  // R11
  end

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_ast_pad
    AST_OUT_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(out_sel[n]) <= 1 |-> pad_oe_o[n] && pad_out_o[n] == out_sel[n][0]);  // R5
    AST_OUT_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(out_sel[n]) == 2 |-> !pad_oe_o[n] && !pad_out_o[n]);  // R6
    for (genvar s = 0; s < NUM_PERIPH_OUT; s++) begin : g_s
      AST_OUT_PERIPH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(out_sel[n]) == 3 + s
        |-> pad_out_o[n] == periph_out_i[s] && pad_oe_o[n] == periph_oe_i[s]);  // R7
    end
    AST_OUT_OOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(out_sel[n]) >= 3 + int'(NUM_PERIPH_OUT) |-> !pad_oe_o[n] && !pad_out_o[n]);  // R8
    AST_OUT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_bank_i && int'(wr_idx_i) == n) |=> $stable(out_sel[n]));  // R11
  end
endmodule

// File: tb/pad_route_mux_tb.sv
module pad_route_mux_tb;
  localparam int NP = 8, NI = 6, NO = 6;
  localparam int IN_W = $clog2(2 + NP), OUT_W = $clog2(3 + NO);
  localparam int DW = (IN_W > OUT_W) ? IN_W : OUT_W;
  localparam int IW = $clog2((NP > NI) ? NP : NI);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_bank = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NP-1:0] pad_in = '0;
  logic [NO-1:0] p_out = '0, p_oe = '0;
  logic [NI-1:0] periph_in;
  logic [NP-1:0] pad_out, pad_oe;

  int total = 0, bad = 0;
  int ref_in[NI];
  int ref_out[NP];
  bit cmp_en = 0;

  always #4 clk = ~clk;

  pad_route_mux #(.NUM_PADS(NP), .NUM_PERIPH_IN(NI), .NUM_PERIPH_OUT(NO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_bank_i(wr_bank),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .pad_in_i(pad_in),
    .periph_out_i(p_out), .periph_oe_i(p_oe),
    .periph_in_o(periph_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe));

  function automatic string in_tag(int c);
    if (c == 0) return "R1";
    if (c == 1) return "R2";
    if (c < 2 + NP) return "R3";
    return "R4";
  endfunction

  function automatic string out_tag(int c);
    if (c <= 1) return "R5";
    if (c == 2) return "R6";
    if (c < 3 + NO) return "R7";
    return "R8";
  endfunction

  task automatic check_all(string phase);
    for (int i = 0; i < NI; i++) begin
      int c = ref_in[i];
      logic e = (c == 1) ? 1'b1 : (c >= 2 && c < 2 + NP) ? pad_in[c-2] : 1'b0;
      total++;
      if (periph_in[i] !== e) begin
        bad++;
        $display("FAIL %s %s periph_in[%0d] code=%0d got=%b exp=%b",
                 in_tag(c), phase, i, c, periph_in[i], e);
      end
    end
    for (int n = 0; n < NP; n++) begin
      int c = ref_out[n];
      logic eo, ee;
      if (c <= 1) begin eo = c[0]; ee = 1'b1; end
      else if (c >= 3 && c < 3 + NO) begin eo = p_out[c-3]; ee = p_oe[c-3]; end
      else begin eo = 1'b0; ee = 1'b0; end
      total++;
      if (pad_out[n] !== eo || pad_oe[n] !== ee) begin
        bad++;
        $display("FAIL %s %s pad[%0d] code=%0d got=%b/%b exp=%b/%b",
                 out_tag(c), phase, n, c, pad_out[n], pad_oe[n], eo, ee);
      end
    end
  endtask

  always @(negedge clk) if (cmp_en) check_all("clk");

  task automatic wr(bit bank, int idx, int data);
    @(posedge clk); #1;
    wr_en = 1; wr_bank = bank; wr_idx = IW'(idx); wr_data = DW'(data);
    @(posedge clk);
    if (!bank && idx < NI) ref_in[idx] = data & ((1 << IN_W) - 1);
    if (bank && idx < NP)  ref_out[idx] = data & ((1 << OUT_W) - 1);
    #1 wr_en = 0;
  endtask

  task automatic stim(int cycles);
    repeat (cycles) begin
      @(posedge clk); #1;
      pad_in = NP'($urandom); p_out = NO'($urandom); p_oe = NO'($urandom);
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (ref_in[i]) ref_in[i] = 0;
    foreach (ref_out[n]) ref_out[n] = 0;
    pad_in = '1; p_out = '1; p_oe = '1;
    #20;
    check_all("R9 in-reset");
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check_all("R9 after-reset");
    cmp_en = 1;

    // R1..R4 sweep every input code of every entry (R10 writes)
    for (int i = 0; i < NI; i++)
      for (int c = 0; c < (1 << IN_W); c++) begin
        wr(0, i, c);
        stim(3);
      end

    // R5..R8 sweep every output code of every pad
    for (int n = 0; n < NP; n++)
      for (int c = 0; c < (1 << OUT_W); c++) begin
        wr(1, n, c);
        stim(3);
      end

    // R11: indices past the input bank change nothing
    for (int i = 0; i < NI; i++) wr(0, i, 2 + i);
    wr(0, NI, 1);
    wr(0, (1 << IW) - 1, 1);
    stim(2);
    @(negedge clk); check_all("R11 bad-index");

    // R12: mid-cycle toggles reach outputs without an edge
    wr(0, 0, 2);
    wr(1, 0, 3);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      pad_in[0] = ~pad_in[0]; p_out[0] = ~p_out[0]; p_oe[0] = ~p_oe[0];
      #1 check_all("R12 comb");
    end

    // R10 random mix of writes and traffic
    for (int k = 0; k < 400; k++) begin
      wr(bit'($urandom_range(0, 1)), $urandom_range(0, (1 << IW) - 1),
         $urandom_range(0, (1 << DW) - 1));
      stim(1);
    end

    cmp_en = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule